// File: doc/BRIEF.md
# Page Map Flag Update Unit

On each processor memory reference, this unit checks the status field of one virtual memory map entry and updates it. A request gives an access kind (read or write), a 2-bit address-source tag and two candidate bank values and two candidate offset words. The tag picks which bank and which offset make up the virtual address. That address indexes an internal map RAM. The unit fetches the entry and decodes its 2-bit status field. It then takes one of two paths:

- It ORs the needed status bits into the entry, writes the entry back, reads the entry again and strobes `retry` so the caller repeats the access.
- It strobes `trap` with a fault code and captures the faulting address into two fault parameter registers.

The surrounding system loads the map RAM through a fill port while the unit is idle, and it can read any entry through a monitor port. The controller has the states IDLE, FETCH, JUDGE, REREAD, RETURN and TRAP. Its transitions are:

- IDLE→FETCH when a request is accepted.
- FETCH→JUDGE unconditionally.
- JUDGE→REREAD when the access is allowed.
- JUDGE→TRAP when the access is refused.
- REREAD→RETURN unconditionally.
- RETURN→IDLE and TRAP→IDLE unconditionally.

Top module: `pmf_unit`

## Requirements
- R1: A request (`req_valid` high at a rising edge) is accepted only while `busy` is low. `busy` is high from the edge after acceptance until the `retry` or `trap` cycle, inclusive. A request presented while `busy` is high is ignored.
- R2: The entry's status field is bits [1:0], the referenced bit is bit 4 and the dirty bit is bit 5. For a read with status 0, 1 or 2, the entry is written back with bit 4 set and all other bits unchanged.
- R3: For a read with status 3, the unit raises a page-fault trap (code 1) and leaves the entry unchanged.
- R4: For a write with status 0 or 2, the entry is written back with bits 4 and 5 set and all other bits unchanged.
- R5: For a write, status 1 raises a write-protect trap (code 2) and status 3 raises a page-fault trap (code 1). In both cases the entry is left unchanged. Write-protect never occurs on a read.
- R6: After a successful update the entry is read again from the map. `retry` is high for exactly one cycle, the fourth cycle after the accepting edge, and `entry_out` then holds the re-read entry.
- R7: `trap` is high for exactly one cycle, the third cycle after the accepting edge. `trap_code` is nonzero only in that cycle. `trap` and `retry` are never high together.
- R8: On a trap, `fault_p0` takes the selected offset word and `fault_p1` takes the selected bank value. Both hold their values otherwise.
- R9: Tag bit 1 selects `bank_b` over `bank_a` and tag bit 0 selects `off_b` over `off_a`. The map index is {bank, offset[7:4]}.
- R10: During reset `busy`, `retry` and `trap` are low, and `trap_code`, `fault_p0`, `fault_p1` and `entry_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_tag | input | 2 | address-source tag |
| bank_a | input | 4 | bank candidate A |
| bank_b | input | 4 | bank candidate B |
| off_a | input | 8 | offset candidate A |
| off_b | input | 8 | offset candidate B |
| fill_en | input | 1 | map load strobe |
| fill_idx | input | 8 | map load index |
| fill_data | input | 8 | map load entry |
| mon_idx | input | 8 | monitor read index |
| mon_entry | output | 8 | entry at `mon_idx` |
| busy | output | 1 | request in progress |
| retry | output | 1 | update done, repeat access |
| entry_out | output | 8 | re-read entry |
| trap | output | 1 | trap strobe |
| trap_code | output | 2 | 0 none, 1 page fault, 2 write protect |
| fault_p0 | output | 8 | captured faulting offset |
| fault_p1 | output | 4 | captured faulting bank |

## Verification
On every clock, the assertions check the following:

- the strobes are one cycle long and never high together;
- `retry` and `trap` land a fixed number of cycles after `busy` rises;
- `trap_code` is nonzero only in the `trap` cycle, and write-protect only follows a write;
- the fault parameters change only when `trap` rises.

The bench's reference model and directed scenarios cover the rest:

- that the right bits are ORed into the right entry;
- that a trapped entry stays untouched;
- that the tag steers both the map index and the captured address;
- that requests held during `busy` are dropped.

// File: rtl/pmf_pkg.sv
`timescale 1ns/1ps
package pmf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_JUDGE  = 3'd2,
        ST_REREAD = 3'd3,
        ST_RETURN = 3'd4,
        ST_TRAP   = 3'd5
    } pmf_state_e;

    typedef enum logic [1:0] {
        TC_NONE  = 2'd0,
        TC_PAGE  = 2'd1,
        TC_WPROT = 2'd2
    } pmf_trap_e;

    // meaning of the two status bits of a map entry
    typedef enum logic [1:0] {
        FL_OPEN_A = 2'd0,
        FL_RDONLY = 2'd1,
        FL_OPEN_B = 2'd2,
        FL_ABSENT = 2'd3
    } pmf_flag_e;

endpackage

// File: rtl/pmf_map_ram.sv
`timescale 1ns/1ps
module pmf_map_ram #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr_a,
    output logic [ENTRY_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]   raddr_b,
    output logic [ENTRY_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata_a = store[raddr_a];
    assign rdata_b = store[raddr_b];
endmodule

// File: rtl/pmf_src_mux.sv
`timescale 1ns/1ps
module pmf_src_mux #(
    parameter int BANK_W = 4,
    parameter int LOW_W  = 8,
    parameter int OFS_W  = 4
) (
    input  logic [1:0]                    tag,
    input  logic [BANK_W-1:0]             bank_a,
    input  logic [BANK_W-1:0]             bank_b,
    input  logic [LOW_W-1:0]              off_a,
    input  logic [LOW_W-1:0]              off_b,
    output logic [BANK_W-1:0]             bank_sel,
    output logic [LOW_W-1:0]              off_sel,
    output logic [BANK_W+LOW_W-OFS_W-1:0] page_idx
);
    always_comb begin
        bank_sel = tag[1] ? bank_b : bank_a;
        off_sel  = tag[0] ? off_b  : off_a;
        page_idx = {bank_sel, off_sel[LOW_W-1:OFS_W]};
    end
endmodule

// File: rtl/pmf_flag_judge.sv
`timescale 1ns/1ps
module pmf_flag_judge
    import pmf_pkg::*;
#(
    parameter int ENTRY_W   = 8,
    parameter int FLAG_LSB  = 0,
    parameter int REF_BIT   = 4,
    parameter int DIRTY_BIT = 5
) (
    input  logic               is_write,
    input  logic [ENTRY_W-1:0] entry,
    output logic               allow,
    output logic [ENTRY_W-1:0] entry_new,
    output pmf_trap_e          code
);
    localparam logic [ENTRY_W-1:0] REF_MASK   = ENTRY_W'(1) << REF_BIT;
    localparam logic [ENTRY_W-1:0] DIRTY_MASK = ENTRY_W'(1) << DIRTY_BIT;

    pmf_flag_e flag;

    always_comb begin
        flag      = pmf_flag_e'(entry[FLAG_LSB +: 2]);
        allow     = 1'b0;
        code      = TC_NONE;
        entry_new = entry;
        if (!is_write) begin
            unique case (flag)
                FL_OPEN_A, FL_RDONLY, FL_OPEN_B: begin
                    allow     = 1'b1;
                    entry_new = entry | REF_MASK;
                end
                FL_ABSENT: code = TC_PAGE;
            endcase
        end else begin
            unique case (flag)
                FL_OPEN_A, FL_OPEN_B: begin
                    allow     = 1'b1;
                    entry_new = entry | REF_MASK | DIRTY_MASK;
                end
                FL_RDONLY: code = TC_WPROT;
                FL_ABSENT: code = TC_PAGE;
            endcase
        end
    end
endmodule

// File: rtl/pmf_unit.sv
`timescale 1ns/1ps
module pmf_unit
    import pmf_pkg::*;
#(
    parameter int BANK_W    = 4,
    parameter int LOW_W     = 8,
    parameter int OFS_W     = 4,
    parameter int ENTRY_W   = 8,
    parameter int FLAG_LSB  = 0,
    parameter int REF_BIT   = 4,
    parameter int DIRTY_BIT = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [1:0]                    req_tag,
    input  logic [BANK_W-1:0]             bank_a,
    input  logic [BANK_W-1:0]             bank_b,
    input  logic [LOW_W-1:0]              off_a,
    input  logic [LOW_W-1:0]              off_b,
    input  logic                          fill_en,
    input  logic [BANK_W+LOW_W-OFS_W-1:0] fill_idx,
    input  logic [ENTRY_W-1:0]            fill_data,
    input  logic [BANK_W+LOW_W-OFS_W-1:0] mon_idx,
    output logic [ENTRY_W-1:0]            mon_entry,
    output logic                          busy,
    output logic                          retry,
    output logic [ENTRY_W-1:0]            entry_out,
    output logic                          trap,
    output logic [1:0]                    trap_code,
    output logic [LOW_W-1:0]              fault_p0,
    output logic [BANK_W-1:0]             fault_p1
);
    localparam int IDX_W = BANK_W + LOW_W - OFS_W;

    pmf_state_e         state_q, state_d;
    logic               req_wr_q;
    logic [IDX_W-1:0]   idx_q;
    logic [LOW_W-1:0]   low_q;
    logic [BANK_W-1:0]  bank_q;
    logic [ENTRY_W-1:0] entry_q;
    logic [ENTRY_W-1:0] out_q;
    pmf_trap_e          code_q;
    logic [LOW_W-1:0]   p0_q;
    logic [BANK_W-1:0]  p1_q;

    logic [BANK_W-1:0]  sel_bank;
    logic [LOW_W-1:0]   sel_low;
    logic [IDX_W-1:0]   sel_idx;
    logic               allow;
    logic [ENTRY_W-1:0] entry_upd;
    pmf_trap_e          judge_code;
    logic [ENTRY_W-1:0] rd_a;
    logic               upd_we, ram_we;
    logic [IDX_W-1:0]   ram_waddr;
    logic [ENTRY_W-1:0] ram_wdata;
    logic               accept;

    pmf_src_mux #(.BANK_W(BANK_W), .LOW_W(LOW_W), .OFS_W(OFS_W)) u_src (
        .tag(req_tag), .bank_a(bank_a), .bank_b(bank_b),
        .off_a(off_a), .off_b(off_b),
        .bank_sel(sel_bank), .off_sel(sel_low), .page_idx(sel_idx)
    );

    pmf_flag_judge #(.ENTRY_W(ENTRY_W), .FLAG_LSB(FLAG_LSB),
                     .REF_BIT(REF_BIT), .DIRTY_BIT(DIRTY_BIT)) u_judge (
        .is_write(req_wr_q), .entry(entry_q),
        .allow(allow), .entry_new(entry_upd), .code(judge_code)
    );

    // the update write wins over a fill in the same cycle
    always_comb begin
        upd_we    = (state_q == ST_JUDGE) && allow;
        ram_we    = upd_we || fill_en;
        ram_waddr = upd_we ? idx_q : fill_idx;
        ram_wdata = upd_we ? entry_upd : fill_data;
    end

    pmf_map_ram #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr_a(idx_q), .rdata_a(rd_a),
        .raddr_b(mon_idx), .rdata_b(mon_entry)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_JUDGE;
            ST_JUDGE:  state_d = allow ? ST_REREAD : ST_TRAP;
            ST_REREAD: state_d = ST_RETURN;
            ST_RETURN: state_d = ST_IDLE;
            ST_TRAP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture, entry registers and fault parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_wr_q <= 1'b0;
            idx_q    <= '0;
            low_q    <= '0;
            bank_q   <= '0;
            entry_q  <= '0;
            out_q    <= '0;
            code_q   <= TC_NONE;
            p0_q     <= '0;
            p1_q     <= '0;
        end else begin
            if (accept) begin
                req_wr_q <= req_write;
                idx_q    <= sel_idx;
                low_q    <= sel_low;
                bank_q   <= sel_bank;
            end
            if (state_q == ST_FETCH) begin
                entry_q <= rd_a;
            end
            if ((state_q == ST_JUDGE) && !allow) begin
                code_q <= judge_code;
                p0_q   <= low_q;
                p1_q   <= bank_q;
            end
            if (state_q == ST_REREAD) begin
                out_q <= rd_a;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        retry     = (state_q == ST_RETURN);
        trap      = (state_q == ST_TRAP);
        trap_code = trap ? code_q : TC_NONE;
        entry_out = out_q;
        fault_p0  = p0_q;
        fault_p1  = p1_q;
    end
endmodule

// File: rtl/pmf_unit_chk.sv
`timescale 1ns/1ps
module pmf_unit_chk #(
    parameter int BANK_W = 4,
    parameter int LOW_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              retry,
    input logic              trap,
    input logic [1:0]        trap_code,
    input logic [LOW_W-1:0]  fault_p0,
    input logic [BANK_W-1:0] fault_p1,
    input logic              req_wr_q
);
    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R6
    retry_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> (!retry && !busy));

    // R6
    retry_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> ($past(busy, 3) && !$past(busy, 4)));

    // R7
    trap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (!trap && !busy));

    // R7
    trap_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> ($past(busy, 2) && !$past(busy, 3)));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap && retry));

    // R7
    code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_code != 2'd0) == trap);

    // R5
    wprot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_code == 2'd2) |-> req_wr_q);

    // R8
    param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(fault_p0) && $stable(fault_p1)) |-> $rose(trap));
endmodule

bind pmf_unit pmf_unit_chk #(.BANK_W(BANK_W), .LOW_W(LOW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .retry(retry), .trap(trap), .trap_code(trap_code),
    .fault_p0(fault_p0), .fault_p1(fault_p1), .req_wr_q(req_wr_q)
);

// File: tb/pmf_unit_tb.sv
`timescale 1ns/1ps
module pmf_unit_tb;
    localparam int BANK_W = 4;
    localparam int LOW_W  = 8;
    localparam int OFS_W  = 4;
    localparam int IDX_W  = BANK_W + LOW_W - OFS_W;
    localparam int DEPTH  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_tag = '0;
    logic [BANK_W-1:0] bank_a = '0, bank_b = '0;
    logic [LOW_W-1:0] off_a = '0, off_b = '0;
    logic fill_en = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0, mon_idx = '0;
    logic [7:0] fill_data = '0;
    logic [7:0] mon_entry, entry_out;
    logic busy, retry, trap;
    logic [1:0] trap_code;
    logic [LOW_W-1:0] fault_p0;
    logic [BANK_W-1:0] fault_p1;

    always #2.5 clk = ~clk;

    pmf_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_tag(req_tag), .bank_a(bank_a), .bank_b(bank_b), .off_a(off_a),
        .off_b(off_b), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_data(fill_data), .mon_idx(mon_idx), .mon_entry(mon_entry),
        .busy(busy), .retry(retry), .entry_out(entry_out), .trap(trap),
        .trap_code(trap_code), .fault_p0(fault_p0), .fault_p1(fault_p1)
    );

    int n_tot = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference model
    int mem_m [DEPTH];
    int m_phase = 0;
    int m_wr, m_idx, m_low, m_bank, m_code, m_p0, m_p1, m_out;
    bit saw_trap, saw_retry;
    int saw_code;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int page_of(int bank, int low);
        return bank * (1 << (LOW_W - OFS_W)) + (low >> OFS_W);
    endfunction

    task automatic model_step();
        int f;
        if (!rst_n) begin
            m_phase = 0; m_p0 = 0; m_p1 = 0; m_out = 0; m_code = 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    m_wr   = req_write;
                    m_bank = req_tag[1] ? int'(bank_b) : int'(bank_a);
                    m_low  = req_tag[0] ? int'(off_b) : int'(off_a);
                    m_idx  = page_of(m_bank, m_low);
                    m_phase = 1;
                end
                1: m_phase = 2;
                2: begin
                    f = mem_m[m_idx] % 4;
                    if (f == 3) m_code = 1;
                    else if (m_wr != 0 && f == 1) m_code = 2;
                    else m_code = 0;
                    if (m_code != 0) begin
                        m_p0 = m_low; m_p1 = m_bank; m_phase = 5;
                    end else begin
                        mem_m[m_idx] = mem_m[m_idx] | ((m_wr != 0) ? 'h30 : 'h10);
                        m_phase = 3;
                    end
                end
                3: begin m_out = mem_m[m_idx]; m_phase = 4; end
                default: m_phase = 0;
            endcase
        end
        if (fill_en) mem_m[fill_idx] = fill_data;
    endtask

    task automatic compare();
        chk("R1 busy", busy, m_phase != 0);
        chk("R6 retry", retry, m_phase == 4);
        chk("R7 trap", trap, m_phase == 5);
        chk("R7 trap_code", trap_code, (m_phase == 5) ? m_code : 0);
        if (m_phase == 4) chk("R6 entry_out", entry_out, m_out);
        chk("R8 fault_p0", fault_p0, m_p0);
        chk("R8 fault_p1", fault_p1, m_p1);
        if (rst_n) chk("R2 map entry", mon_entry, mem_m[mon_idx]);
        if (trap) begin saw_trap = 1; saw_code = trap_code; end
        if (retry) saw_retry = 1;
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run_req(bit w, logic [1:0] tag);
        saw_trap = 0; saw_retry = 0; saw_code = 0;
        req_valid = 1; req_write = w; req_tag = tag;
        tick();
        req_valid = 0;
        for (int k = 0; k < 8 && m_phase != 0; k++) tick();
    endtask

    task automatic directed(bit w, logic [1:0] tag, int flag);
        int ba, bb, oa, ob, sb, so, idx, v, exp_code, exp_v;
        ba = $urandom % 16; bb = 15 - ba;
        oa = $urandom % 256; ob = oa ^ 'h50;
        sb = tag[1] ? bb : ba;
        so = tag[0] ? ob : oa;
        idx = page_of(sb, so);
        v = ($urandom & 'hCC) | flag;
        bank_a = BANK_W'(ba); bank_b = BANK_W'(bb);
        off_a = LOW_W'(oa); off_b = LOW_W'(ob);
        fill_en = 1; fill_idx = IDX_W'(idx); fill_data = 8'(v);
        tick();
        fill_en = 0; mon_idx = IDX_W'(idx);
        tick();
        run_req(w, tag);
        exp_code = (flag == 3) ? 1 : ((w && flag == 1) ? 2 : 0);
        exp_v = (exp_code != 0) ? v : (v | (w ? 'h30 : 'h10));
        if (!w && exp_code == 0) chk("R2 read sets referenced", mon_entry, exp_v);
        if (w && exp_code == 0)  chk("R4 write sets ref+dirty", mon_entry, exp_v);
        if (!w && exp_code != 0) chk("R3 read fault keeps entry", mon_entry, exp_v);
        if (w && exp_code != 0)  chk("R5 write trap keeps entry", mon_entry, exp_v);
        chk("R5 trap seen", saw_trap, exp_code != 0);
        chk("R3 trap code", saw_code, exp_code);
        chk("R6 retry seen", saw_retry, exp_code == 0);
        if (exp_code != 0) begin
            chk("R9 fault offset source", fault_p0, so);
            chk("R9 fault bank source", fault_p1, sb);
        end
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_bad++; n_tot++;
            $display("FAIL R1 watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 retry", retry, 0);
        chk("R10 trap", trap, 0);
        chk("R10 trap_code", trap_code, 0);
        chk("R10 fault_p0", fault_p0, 0);
        chk("R10 fault_p1", fault_p1, 0);
        chk("R10 entry_out", entry_out, 0);
        rst_n = 1;
        for (int i = 0; i < DEPTH; i++) begin
            fill_en = 1; fill_idx = IDX_W'(i); fill_data = 8'($urandom);
            tick();
        end
        fill_en = 0;
        tick();
        // every access kind against every status value, tags rotating
        for (int w = 0; w < 2; w++)
            for (int f = 0; f < 4; f++)
                directed(w[0], 2'((w * 4 + f) % 4), f);
        // R9 every tag on a page fault and on a clean update
        for (int t = 0; t < 4; t++) directed(1'b0, 2'(t), 3);
        for (int t = 0; t < 4; t++) directed(1'b1, 2'(t), 2);
        // R1 request held high through busy: extra requests are dropped
        bank_a = 4'h3; off_a = 8'h20; req_tag = 2'd0; mon_idx = IDX_W'(page_of(3, 'h20));
        req_valid = 1; req_write = 1;
        for (int k = 0; k < 13; k++) begin
            off_b = 8'($urandom);
            tick();
        end
        req_valid = 0;
        for (int k = 0; k < 8; k++) tick();
        // random traffic
        for (int n = 0; n < 200; n++) begin
            if ($urandom % 4 == 0) begin
                fill_en = 1; fill_idx = IDX_W'($urandom); fill_data = 8'($urandom);
                tick();
                fill_en = 0;
            end
            bank_a = BANK_W'($urandom); bank_b = BANK_W'($urandom);
            off_a = LOW_W'($urandom); off_b = LOW_W'($urandom);
            req_tag = 2'($urandom);
            mon_idx = IDX_W'(page_of(req_tag[1] ? int'(bank_b) : int'(bank_a),
                                     req_tag[0] ? int'(off_b) : int'(off_a)));
            run_req(1'($urandom), req_tag);
            for (int k = 0; k < int'($urandom % 3); k++) tick();
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule